// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, once per cycle, which of eight resident hardware thread contexts a fine-grained multithreaded core issues from. Every context keeps its own architectural state outside this block, so changing threads costs no save or restore. The selector only has to name the thread. A thread is eligible in a cycle when its ready bit is set and its stall bit is clear.

A two-bit policy input picks one of three switching rules:
- **Switch-on-stall:** keep issuing from one thread until it can no longer issue.
- **Switch-every-cycle:** rotate round-robin across all eight threads.
- **Dual-pipeline interleave:** threads 0 to 3 feed pipeline 0 and threads 4 to 7 feed pipeline 1. Each group has its own round-robin pointer, so at most two threads issue per cycle.

The outputs are one thread number per pipeline, each with a valid flag. They are a plain combinational function of the current inputs and the internal pointer state. There is no downstream back-pressure: the core takes a valid grant in the cycle it appears. If the core cannot take it, it holds `sel_en` low, which freezes all selector state.

Top module: `tsel_top`

## Requirements
- R1: After reset the policy is switch-on-stall (code 0) and every pointer is at thread 0. With all threads eligible, the first grant is thread 0.
- R2: A thread number is only reported valid when that thread is eligible (`thr_ready` bit set, `thr_stall` bit clear) in the same cycle.
- R3: While `sel_en` is low, both valid flags are low and no pointer moves.
- R4: With policy code 1, pipeline 0 grants the first eligible thread at or after the pointer, in circular order over threads 0 to 7. The pointer then moves to the thread just after the grant. `pipe1_vld` stays low.
- R5: With policy code 2, pipeline 0 grants only threads 0 to 3 and pipeline 1 grants only threads 4 to 7. Each group is round-robin from its own pointer, and after a grant that pointer moves to just past the granted thread.
- R6: With policy code 2, a group with no eligible thread drives its valid flag low and its pointer stays unchanged.
- R7: With policy code 0, the current thread keeps the grant for as long as it stays eligible.
- R8: With policy code 0, when the current thread is not eligible, the grant moves to the next eligible thread after it in circular order, and that thread becomes current. If no thread is eligible, no grant is made and the current thread is kept.
- R9: A change of `sel_mode` takes effect from the next cycle. At that clock edge all pointers, including the current thread of code 0, return to thread 0, whatever the value of `sel_en`.
- R10: Policy code 3 issues nothing: both valid flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_en | input | 1 | Issue enable; low freezes the selector |
| sel_mode | input | 2 | Policy: 0 switch-on-stall, 1 every-cycle, 2 dual-pipeline, 3 idle |
| thr_ready | input | 8 | Per-thread ready bits |
| thr_stall | input | 8 | Per-thread stall bits |
| pipe0_vld | output | 1 | Pipeline 0 grant is valid |
| pipe0_tid | output | 3 | Thread granted to pipeline 0 |
| pipe1_vld | output | 1 | Pipeline 1 grant is valid |
| pipe1_tid | output | 3 | Thread granted to pipeline 1 |

## Verification
**Switch-on-stall.** With every thread eligible, the bench confirms that the grant sticks to one thread. Single-thread stalls then show the grant hopping forward to the next eligible thread. A cycle with nothing eligible shows that the grant is dropped while the current thread is remembered.

**Every-cycle and dual-pipeline.** Full and sparse eligibility vectors separate a true round-robin from a fixed priority. A group left empty in dual-pipeline mode shows that the two pointers are independent.

**Mode changes and enable.** Long runs of random eligibility, enable and mode changes test the pointer reset on a policy change and the freeze under a low enable. Each cycle is compared against a behavioural model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [1:0] {
    SEL_BLOCKED    = 2'd0,
    SEL_INTERLEAVE = 2'd1,
    SEL_DUAL       = 2'd2,
    SEL_OFF        = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/tsel_rr_pick.sv
// Circular first-eligible search starting at a pointer.
module tsel_rr_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         found,
  output logic [W-1:0] idx
);
  logic [W-1:0] cand;

  always_comb begin
    found = 1'b0;
    idx   = start;
    cand  = '0;
    for (int k = 0; k < N; k++) begin
      cand = start + W'(k);
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/tsel_ptr_reg.sv
// Pointer register with clear (policy change) and load (grant).
module tsel_ptr_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (clr)  ptr <= '0;
    else if (load) ptr <= nxt;
  end
endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  localparam int GRP = NUM_THREADS / 2,
  localparam int TW  = $clog2(NUM_THREADS),
  localparam int GW  = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_en,
  input  logic [1:0]             sel_mode,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [NUM_THREADS-1:0] thr_stall,
  output logic                   pipe0_vld,
  output logic [TW-1:0]          pipe0_tid,
  output logic                   pipe1_vld,
  output logic [TW-1:0]          pipe1_tid
);
  sel_mode_e              mode_q;
  logic                   mode_chg;
  logic [NUM_THREADS-1:0] elig;

  assign elig     = thr_ready & ~thr_stall;
  assign mode_chg = (sel_mode_e'(sel_mode) != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= SEL_BLOCKED;
    else if (mode_chg) mode_q <= sel_mode_e'(sel_mode);
  end

  // Whole-core pointer: current thread (blocked) or next start (interleaved)
  logic          all_found;
  logic [TW-1:0] all_idx, all_ptr, all_nxt;
  logic          all_load;

  tsel_rr_pick #(.N(NUM_THREADS)) u_pick_all (
    .req(elig), .start(all_ptr), .found(all_found), .idx(all_idx)
  );

  assign all_nxt  = (mode_q == SEL_BLOCKED) ? all_idx : all_idx + TW'(1);
  assign all_load = sel_en && all_found &&
                    (mode_q == SEL_BLOCKED || mode_q == SEL_INTERLEAVE);

  tsel_ptr_reg #(.W(TW)) u_ptr_all (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .load(all_load),
    .nxt(all_nxt), .ptr(all_ptr)
  );

  // Per-pipeline group pointers for dual-pipeline interleave
  logic          grp_found [2];
  logic [GW-1:0] grp_idx   [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_grp
    logic [GW-1:0] gptr;
    logic          gload;

    tsel_rr_pick #(.N(GRP)) u_pick (
      .req(elig[gi*GRP +: GRP]), .start(gptr),
      .found(grp_found[gi]), .idx(grp_idx[gi])
    );

    assign gload = sel_en && grp_found[gi] && (mode_q == SEL_DUAL);

    tsel_ptr_reg #(.W(GW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg), .load(gload),
      .nxt(grp_idx[gi] + GW'(1)), .ptr(gptr)
    );
  end

  always_comb begin
    pipe0_vld = 1'b0;
    pipe0_tid = '0;
    pipe1_vld = 1'b0;
    pipe1_tid = TW'(GRP);
    unique case (mode_q)
      SEL_BLOCKED, SEL_INTERLEAVE: begin
        pipe0_vld = sel_en && all_found;
        pipe0_tid = all_idx;
      end
      SEL_DUAL: begin
        pipe0_vld = sel_en && grp_found[0];
        pipe0_tid = TW'(grp_idx[0]);
        pipe1_vld = sel_en && grp_found[1];
        pipe1_tid = TW'(GRP) + TW'(grp_idx[1]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk #(
  parameter int NUM_THREADS = 8,
  localparam int GRP = NUM_THREADS / 2,
  localparam int TW  = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sel_en,
  input logic [1:0]             sel_mode,
  input logic [NUM_THREADS-1:0] thr_ready,
  input logic [NUM_THREADS-1:0] thr_stall,
  input logic                   pipe0_vld,
  input logic [TW-1:0]          pipe0_tid,
  input logic                   pipe1_vld,
  input logic [TW-1:0]          pipe1_tid
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pipe0_vld |-> (thr_ready[pipe0_tid] && !thr_stall[pipe0_tid])); // R2

  AST_PIPE1_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pipe1_vld |-> (thr_ready[pipe1_tid] && !thr_stall[pipe1_tid])); // R2

  AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |-> (!pipe0_vld && !pipe1_vld)); // R3

  AST_PIPE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    pipe1_vld |-> (pipe1_tid >= TW'(GRP) && (!pipe0_vld || pipe0_tid < TW'(GRP)))); // R5

  AST_SINGLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2 && $past(sel_mode) == 2'd1) |-> !pipe1_vld); // R4

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2 && $past(sel_mode) == 2'd3) |-> (!pipe0_vld && !pipe1_vld)); // R10

  AST_BLOCKED_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3 && $past(sel_mode, 2) == 2'd0 && $past(sel_mode) == 2'd0 &&
     $past(sel_en) && $past(pipe0_vld) && sel_en &&
     thr_ready[$past(pipe0_tid)] && !thr_stall[$past(pipe0_tid)])
    |-> (pipe0_vld && pipe0_tid == $past(pipe0_tid))); // R7
endmodule

bind tsel_top tsel_chk #(.NUM_THREADS(NUM_THREADS)) u_tsel_chk (
  .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .sel_mode(sel_mode),
  .thr_ready(thr_ready), .thr_stall(thr_stall),
  .pipe0_vld(pipe0_vld), .pipe0_tid(pipe0_tid),
  .pipe1_vld(pipe1_vld), .pipe1_tid(pipe1_tid)
);

// File: tb/tb_tsel_top.sv
`timescale 1ns/1ps
module tb_tsel_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_en;
  logic [1:0] sel_mode;
  logic [7:0] thr_ready, thr_stall;
  logic       pipe0_vld, pipe1_vld;
  logic [2:0] pipe0_tid, pipe1_tid;

  always #2.5 clk = ~clk;

  tsel_top dut (
    .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .sel_mode(sel_mode),
    .thr_ready(thr_ready), .thr_stall(thr_stall),
    .pipe0_vld(pipe0_vld), .pipe0_tid(pipe0_tid),
    .pipe1_vld(pipe1_vld), .pipe1_tid(pipe1_tid)
  );

  int  vectors = 0;
  int  miscompares = 0;
  int  m_ptr8 = 0, m_pa = 0, m_pb = 0, m_mode = 0;
  bit  after_rst = 1'b1, after_chg = 1'b0;
  bit  done = 1'b0;

  function automatic int pick(int start, int base, int n, logic [7:0] e);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = base + ((start + k) % n);
      if (e[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic string tag(bit en_i);
    if (after_rst)   return "R1";
    if (after_chg)   return "R9";
    if (!en_i)       return "R3";
    case (m_mode)
      0:       return "R7/R8/R2";
      1:       return "R4/R2";
      2:       return "R5/R6";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input bit en_i, input int mode_i,
                      input logic [7:0] rdy, input logic [7:0] stl);
    logic [7:0] e;
    int  g0, g1;
    bit  ev0, ev1;
    int  et0, et1;
    @(negedge clk);
    sel_en    = en_i;
    sel_mode  = 2'(mode_i);
    thr_ready = rdy;
    thr_stall = stl;
    #1;
    e = rdy & ~stl;
    ev0 = 0; ev1 = 0; et0 = 0; et1 = 0; g0 = -1; g1 = -1;
    if (m_mode == 0 || m_mode == 1) begin
      g0 = pick(m_ptr8, 0, 8, e);
      ev0 = en_i && g0 >= 0; et0 = g0;
    end else if (m_mode == 2) begin
      g0 = pick(m_pa, 0, 4, e);
      g1 = pick(m_pb, 4, 4, e);
      ev0 = en_i && g0 >= 0; et0 = g0;
      ev1 = en_i && g1 >= 0; et1 = g1;
    end
    vectors++;
    if (pipe0_vld !== ev0 || pipe1_vld !== ev1 ||
        (ev0 && pipe0_tid !== 3'(et0)) || (ev1 && pipe1_tid !== 3'(et1))) begin
      miscompares++;
      $display("FAIL %s: got v0=%0b t0=%0d v1=%0b t1=%0d exp v0=%0b t0=%0d v1=%0b t1=%0d",
               tag(en_i), pipe0_vld, pipe0_tid, pipe1_vld, pipe1_tid,
               ev0, et0, ev1, et1);
    end
    after_rst = 0;
    after_chg = 0;
    if (mode_i != m_mode) begin
      m_mode = mode_i; m_ptr8 = 0; m_pa = 0; m_pb = 0; after_chg = 1;
    end else if (en_i) begin
      if (m_mode == 0 && g0 >= 0) m_ptr8 = g0;
      if (m_mode == 1 && g0 >= 0) m_ptr8 = (g0 + 1) % 8;
      if (m_mode == 2 && g0 >= 0) m_pa = (g0 + 1) % 4;
      if (m_mode == 2 && g1 >= 0) m_pb = (g1 - 4 + 1) % 4;
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1..: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int md;
    rst_n = 0; sel_en = 0; sel_mode = 0; thr_ready = 0; thr_stall = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state, then R7 stay
    step(1, 0, 8'hFF, 8'h00);
    repeat (3) step(1, 0, 8'hFF, 8'h00);
    // R8 stall current, moves on
    step(1, 0, 8'hFF, 8'h01);
    step(1, 0, 8'hFF, 8'h02);
    step(1, 0, 8'h00, 8'h00);       // nothing eligible: hold
    step(1, 0, 8'h20, 8'h00);       // only 5
    step(1, 0, 8'h21, 8'h20);       // wraps to 0
    // R3 enable low
    repeat (3) step(0, 0, 8'hFF, 8'h00);
    // R9 change to interleave, R4 rotation
    repeat (10) step(1, 1, 8'hFF, 8'h00);
    repeat (6) step(1, 1, 8'b1001_0010, 8'h00);
    step(0, 1, 8'hFF, 8'h00);
    repeat (4) step(1, 1, 8'hFF, 8'b0100_0000);
    // R5, R6 dual pipeline
    repeat (6) step(1, 2, 8'hFF, 8'h00);
    repeat (4) step(1, 2, 8'hF0, 8'h00);
    repeat (4) step(1, 2, 8'h0F, 8'h00);
    repeat (4) step(1, 2, 8'b1010_0101, 8'b1000_0001);
    // R10 idle code
    repeat (3) step(1, 3, 8'hFF, 8'h00);
    // random mix
    md = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 25 == 0) md = $urandom % 4;
      step(($urandom % 10) != 0, md, 8'($urandom), 8'($urandom) & 8'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule